// File: doc/BRIEF.md
# Descriptor and Link-Table Fetch Engine

This block is the front end of one processing channel. Software pushes 32-bit memory pointers into a small FIFO. For each valid pointer the engine issues one burst read of a fixed 64-byte work descriptor and collects the returned 64-bit beats into an eight-dword descriptor buffer. The register side can read this buffer but cannot write it.

Dword 0 of the descriptor is a header. Dwords 1 to 7 are length/pointer entries 0 to 6. An external step input walks these entries one at a time. When the current entry has its jump flag set, the engine reads a 32-byte, four-entry link table from that entry's pointer into a separate read-only buffer. After a link table lands, the engine looks for an entry with its next flag set. If one exists, the engine fetches the following 32-byte link table from that entry's pointer.

Only one burst is in flight at any time. A pending link-table fetch always goes before a new descriptor is taken from the FIFO. Both buffers change only when a fetch completes, so a reader never sees a partly filled buffer.

Top module: `desc_fetch_engine`

## Requirements
- R1: After reset, every dword of both buffers reads zero, the FIFO is empty, the overflow flag is low, no read request is raised, and no walk is active.
- R2: A push of an aligned pointer, with the engine idle and no walk active, produces one read request at that address with a byte count of 64. The eight returned beats appear in descriptor dwords 0 to 7 in arrival (address) order. `desc_done_o` pulses for one cycle, and the new contents are readable in that same cycle.
- R3: The FIFO holds four pointers. A push while it is full is dropped: the level stays at 4 and `overflow_o` sets and stays set until reset.
- R4: A pushed pointer whose bits 2:0 are not all zero is discarded. It does not enter the FIFO and no fetch is made for it.
- R5: While a fetch is in progress, the buffer being filled keeps its previous contents on the read port until the last beat has landed.
- R6: Entry k sits in descriptor dword k+1. Its fields are length in bits 63:48, jump flag in bit 47, pointer in bits 31:0. Stepping an entry whose jump flag is 1 issues a 32-byte read at its pointer. The four beats land in link-table dwords 0 to 3, and `lt_done_o` pulses.
- R7: A completed descriptor starts a walk at entry 0. A step on an entry without a jump flag makes no fetch and advances the index. Stepping entry 6 ends the walk, and the index then reads 7. A step while no walk is active, or while a fetch is pending or in flight, is ignored.
- R8: A link-table entry carries its next flag in bit 47 and its pointer in bits 31:0. When a link table lands with at least one next flag set, the engine makes another 32-byte read at the pointer of the lowest-indexed flagged entry.
- R9: No new descriptor is taken from the FIFO during a walk. When a step on entry 6 requests a link table and a pointer is waiting in the FIFO, the link-table read is issued first.
- R10: Once a read request is raised, it stays raised with a stable address and byte count until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid_i | input | 1 | Pointer push strobe |
| push_ptr_i | input | 32 | Descriptor pointer to queue |
| fifo_level_o | output | 3 | Pointers waiting in the FIFO |
| overflow_o | output | 1 | Sticky flag: a push hit a full FIFO |
| rd_req_valid_o | output | 1 | Burst read request valid |
| rd_req_ready_i | input | 1 | Memory accepts the request |
| rd_req_addr_o | output | 32 | Burst start address |
| rd_req_bytes_o | output | 7 | Burst length in bytes |
| rd_beat_valid_i | input | 1 | A read beat is present |
| rd_beat_data_i | input | 64 | Read beat data |
| desc_done_o | output | 1 | Descriptor buffer updated this cycle |
| lt_done_o | output | 1 | Link-table buffer updated this cycle |
| step_i | input | 1 | Advance to the next descriptor entry |
| walk_active_o | output | 1 | Descriptor entries remain to be stepped |
| entry_idx_o | output | 3 | Index of the entry the next step examines |
| desc_rd_idx_i | input | 3 | Descriptor buffer read index |
| desc_rd_data_o | output | 64 | Descriptor buffer read data |
| lt_rd_idx_i | input | 2 | Link-table buffer read index |
| lt_rd_data_o | output | 64 | Link-table buffer read data |

## Verification
The bench builds the block with its default parameters. The descriptor is eight dwords, the link table is four, and the FIFO is four deep. With these values a fifth push reaches the overflow drop, and a full seven-entry walk finishes in a few dozen cycles. The bench runs two link tables chained through the lowest of two flagged entries, and a jump on the final entry while another pointer waits in the FIFO. The memory model holds back request acceptance for several cycles and inserts idle cycles between beats. This shows that requests stay stable while waiting and that a partly filled buffer never reaches the read port.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  localparam int DWORD_W  = 64;
  localparam int PTR_W    = 32;
  localparam int FLAG_BIT = 47;  // jump flag in entries, next flag in link entries

  typedef logic [DWORD_W-1:0] dword_t;
  typedef logic [PTR_W-1:0]   ptr_t;

  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_DATA, RD_DONE} rd_state_e;

  function automatic logic flag_of(dword_t d);
    return d[FLAG_BIT];
  endfunction

  function automatic ptr_t ptr_of(dword_t d);
    return d[PTR_W-1:0];
  endfunction

  function automatic logic ptr_ok(ptr_t p);
    return p[2:0] == 3'b000;
  endfunction
endpackage

// File: rtl/dfe_ptr_fifo.sv
module dfe_ptr_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               data_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  store_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = store_q[rd_q];
  assign level_o = lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
    end else begin
      if (do_push) begin
        store_q[wr_q] <= data_i;
        wr_q          <= wrap_inc(wr_q);
      end
      if (do_pop) rd_q <= wrap_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + LW'(1);
        2'b01:   lvl_q <= lvl_q - LW'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  // R3: a push into a full FIFO leaves the level untouched
  a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (level_o == $past(level_o)));
  a_r3_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LW'(DEPTH));
endmodule

// File: rtl/dfe_burst_reader.sv
module dfe_burst_reader
  import dfe_pkg::*;
#(
  parameter int MAX_BEATS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  ptr_t                             start_addr_i,
  input  logic [$clog2(MAX_BEATS):0]       start_beats_i,
  output logic                             req_valid_o,
  input  logic                             req_ready_i,
  output ptr_t                             req_addr_o,
  output logic [$clog2(MAX_BEATS)+3:0]     req_bytes_o,
  input  logic                             beat_valid_i,
  input  dword_t                           beat_data_i,
  output logic                             busy_o,
  output logic                             done_o,
  output dword_t [MAX_BEATS-1:0]           stage_o
);
  localparam int CNT_W  = $clog2(MAX_BEATS);
  localparam int BEAT_W = CNT_W + 1;

  rd_state_e               state_q;
  ptr_t                    addr_q;
  logic [BEAT_W-1:0]       beats_q;
  logic [CNT_W-1:0]        cnt_q;
  dword_t [MAX_BEATS-1:0]  stage_q;
  logic                    last_beat;

  assign last_beat   = (cnt_q == CNT_W'(beats_q - BEAT_W'(1)));
  assign req_valid_o = (state_q == RD_REQ);
  assign req_addr_o  = addr_q;
  assign req_bytes_o = {beats_q, 3'b000};
  assign busy_o      = (state_q != RD_IDLE);
  assign done_o      = (state_q == RD_DONE);
  assign stage_o     = stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      addr_q  <= '0;
      beats_q <= '0;
      cnt_q   <= '0;
      stage_q <= '0;
    end else begin
      unique case (state_q)
        RD_IDLE: if (start_i) begin
          addr_q  <= start_addr_i;
          beats_q <= start_beats_i;
          cnt_q   <= '0;
          state_q <= RD_REQ;
        end
        RD_REQ:  if (req_ready_i) state_q <= RD_DATA;
        RD_DATA: if (beat_valid_i) begin
          stage_q[cnt_q] <= beat_data_i;
          cnt_q          <= cnt_q + CNT_W'(1);
          if (last_beat) state_q <= RD_DONE;
        end
        RD_DONE: state_q <= RD_IDLE;
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  // R10: a raised request holds until accepted
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_bytes_o)));
  // R9: a new fetch is launched only when nothing is in flight
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (state_q == RD_IDLE));
  a_r2_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/dfe_shadow_buf.sv
module dfe_shadow_buf
  import dfe_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  dword_t [DEPTH-1:0] data_i,
  output dword_t [DEPTH-1:0] contents_o,
  output logic               done_o
);
  dword_t [DEPTH-1:0] mem_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= commit_i;
      if (commit_i) mem_q <= data_i;
    end
  end

  assign contents_o = mem_q;
  assign done_o     = done_q;

  // R5: contents change only on a completed fetch
  a_r5_hold_between_commits: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(contents_o));
  a_r2_done_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> done_o);
endmodule

// File: rtl/desc_fetch_engine.sv
module desc_fetch_engine
  import dfe_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int DESC_DWORDS = 8,
  parameter int LT_DWORDS   = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                push_valid_i,
  input  logic [31:0]                         push_ptr_i,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]     fifo_level_o,
  output logic                                overflow_o,
  output logic                                rd_req_valid_o,
  input  logic                                rd_req_ready_i,
  output logic [31:0]                         rd_req_addr_o,
  output logic [$clog2(DESC_DWORDS)+3:0]      rd_req_bytes_o,
  input  logic                                rd_beat_valid_i,
  input  logic [63:0]                         rd_beat_data_i,
  output logic                                desc_done_o,
  output logic                                lt_done_o,
  input  logic                                step_i,
  output logic                                walk_active_o,
  output logic [$clog2(DESC_DWORDS)-1:0]      entry_idx_o,
  input  logic [$clog2(DESC_DWORDS)-1:0]      desc_rd_idx_i,
  output logic [63:0]                         desc_rd_data_o,
  input  logic [$clog2(LT_DWORDS)-1:0]        lt_rd_idx_i,
  output logic [63:0]                         lt_rd_data_o
);
  localparam int ENTRIES = DESC_DWORDS - 1;
  localparam int IDX_W   = $clog2(DESC_DWORDS);
  localparam int BEAT_W  = IDX_W + 1;
  localparam int LVL_W   = $clog2(FIFO_DEPTH+1);

  // FIFO side
  ptr_t              fifo_head;
  logic              fifo_full, fifo_empty, push_ok;
  logic [LVL_W-1:0]  fifo_level;

  // reader side
  logic                     rd_busy, rd_done, rd_start;
  ptr_t                     start_addr;
  logic [BEAT_W-1:0]        start_beats;
  dword_t [DESC_DWORDS-1:0] stage;

  // buffers
  dword_t [DESC_DWORDS-1:0] desc_mem;
  dword_t [LT_DWORDS-1:0]   lt_mem;
  logic                     desc_commit, lt_commit;

  // control state
  logic             lt_pend_q, fetch_lt_q, walk_q, ovf_q;
  ptr_t             lt_addr_q;
  logic [IDX_W-1:0] idx_q;

  // named events
  logic   lt_start, desc_start, step_ok, chain_hit;
  ptr_t   chain_addr;
  dword_t cur_entry;

  assign push_ok    = push_valid_i && ptr_ok(push_ptr_i);
  assign lt_start   = !rd_busy && lt_pend_q;
  assign desc_start = !rd_busy && !lt_pend_q && !walk_q && !fifo_empty;
  assign rd_start   = lt_start || desc_start;
  assign start_addr = lt_start ? lt_addr_q : fifo_head;
  assign start_beats = lt_start ? BEAT_W'(LT_DWORDS) : BEAT_W'(DESC_DWORDS);
  assign step_ok    = step_i && walk_q && !rd_busy && !lt_pend_q;
  assign cur_entry  = desc_mem[idx_q + IDX_W'(1)];
  assign desc_commit = rd_done && !fetch_lt_q;
  assign lt_commit   = rd_done && fetch_lt_q;

  // lowest-indexed link entry with its next flag wins
  always_comb begin
    chain_hit  = 1'b0;
    chain_addr = '0;
    for (int k = LT_DWORDS-1; k >= 0; k--) begin
      if (flag_of(stage[k])) begin
        chain_hit  = 1'b1;
        chain_addr = ptr_of(stage[k]);
      end
    end
  end

  dfe_ptr_fifo #(.DEPTH(FIFO_DEPTH), .W(PTR_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_ok), .data_i(push_ptr_i), .pop_i(desc_start),
    .data_o(fifo_head), .level_o(fifo_level), .full_o(fifo_full), .empty_o(fifo_empty)
  );

  dfe_burst_reader #(.MAX_BEATS(DESC_DWORDS)) u_reader (
    .clk(clk), .rst_n(rst_n),
    .start_i(rd_start), .start_addr_i(start_addr), .start_beats_i(start_beats),
    .req_valid_o(rd_req_valid_o), .req_ready_i(rd_req_ready_i),
    .req_addr_o(rd_req_addr_o), .req_bytes_o(rd_req_bytes_o),
    .beat_valid_i(rd_beat_valid_i), .beat_data_i(rd_beat_data_i),
    .busy_o(rd_busy), .done_o(rd_done), .stage_o(stage)
  );

  dfe_shadow_buf #(.DEPTH(DESC_DWORDS)) u_desc_buf (
    .clk(clk), .rst_n(rst_n), .commit_i(desc_commit), .data_i(stage),
    .contents_o(desc_mem), .done_o(desc_done_o)
  );

  dfe_shadow_buf #(.DEPTH(LT_DWORDS)) u_lt_buf (
    .clk(clk), .rst_n(rst_n), .commit_i(lt_commit), .data_i(stage[LT_DWORDS-1:0]),
    .contents_o(lt_mem), .done_o(lt_done_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lt_pend_q  <= 1'b0;
      lt_addr_q  <= '0;
      fetch_lt_q <= 1'b0;
      walk_q     <= 1'b0;
      idx_q      <= '0;
      ovf_q      <= 1'b0;
    end else begin
      if (lt_commit && chain_hit) begin
        lt_pend_q <= 1'b1;
        lt_addr_q <= chain_addr;
      end else if (step_ok && flag_of(cur_entry)) begin
        lt_pend_q <= 1'b1;
        lt_addr_q <= ptr_of(cur_entry);
      end else if (lt_start) begin
        lt_pend_q <= 1'b0;
      end

      if (rd_start) fetch_lt_q <= lt_start;

      if (desc_commit) begin
        walk_q <= 1'b1;
        idx_q  <= '0;
      end else if (step_ok) begin
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q == IDX_W'(ENTRIES-1)) walk_q <= 1'b0;
      end

      if (push_ok && fifo_full) ovf_q <= 1'b1;
    end
  end

  assign fifo_level_o   = fifo_level;
  assign overflow_o     = ovf_q;
  assign walk_active_o  = walk_q;
  assign entry_idx_o    = idx_q;
  assign desc_rd_data_o = desc_mem[desc_rd_idx_i];
  assign lt_rd_data_o   = lt_mem[lt_rd_idx_i];

  // R2: every burst starts on a dword boundary
  a_r2_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o |-> (rd_req_addr_o[2:0] == 3'b000));
  // R4: a misaligned push never changes the queue
  a_r4_misaligned_not_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_i && !ptr_ok(push_ptr_i) && fifo_empty) |=> (fifo_level_o == '0));
  // R3: overflow flag is sticky
  a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  // R7: the walk index stays within the entry range
  a_r7_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    walk_active_o |-> (entry_idx_o < IDX_W'(ENTRIES)));
  // R9: no descriptor is taken during a walk
  a_r9_no_pop_while_walking: assert property (@(posedge clk) disable iff (!rst_n)
    walk_active_o |=> (fifo_level_o >= $past(fifo_level_o)));
  // R6: link-table bursts are 32 bytes
  a_r6_lt_burst_size: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && fetch_lt_q) |-> (rd_req_bytes_o == {BEAT_W'(LT_DWORDS), 3'b000}));
endmodule

// File: tb/desc_fetch_engine_tb_top.sv
module desc_fetch_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_valid_i;
  logic [31:0] push_ptr_i;
  logic [2:0]  fifo_level_o;
  logic        overflow_o;
  logic        rd_req_valid_o;
  logic        rd_req_ready_i;
  logic [31:0] rd_req_addr_o;
  logic [6:0]  rd_req_bytes_o;
  logic        rd_beat_valid_i;
  logic [63:0] rd_beat_data_i;
  logic        desc_done_o, lt_done_o;
  logic        step_i;
  logic        walk_active_o;
  logic [2:0]  entry_idx_o;
  logic [2:0]  desc_rd_idx_i;
  logic [63:0] desc_rd_data_o;
  logic [1:0]  lt_rd_idx_i;
  logic [63:0] lt_rd_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_fetch_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .push_valid_i(push_valid_i), .push_ptr_i(push_ptr_i),
    .fifo_level_o(fifo_level_o), .overflow_o(overflow_o),
    .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
    .rd_req_addr_o(rd_req_addr_o), .rd_req_bytes_o(rd_req_bytes_o),
    .rd_beat_valid_i(rd_beat_valid_i), .rd_beat_data_i(rd_beat_data_i),
    .desc_done_o(desc_done_o), .lt_done_o(lt_done_o),
    .step_i(step_i), .walk_active_o(walk_active_o), .entry_idx_o(entry_idx_o),
    .desc_rd_idx_i(desc_rd_idx_i), .desc_rd_data_o(desc_rd_data_o),
    .lt_rd_idx_i(lt_rd_idx_i), .lt_rd_data_o(lt_rd_data_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // memory model
  logic [63:0] mem [0:127];
  logic [31:0] log_addr [0:31];
  int          log_len  [0:31];
  int          n_req = 0;
  int          beats_left = 0;
  int          cur_word = 0;
  int          stall_cnt = 0;
  int          stall_seen = 0;
  bit          gap_on = 0;
  bit          gap_t = 0;
  bit          hs_pending = 0;

  function automatic logic [63:0] mk(input logic [15:0] len, input logic fl, input logic [31:0] p);
    return {len, fl, 7'h05, 8'h00, p};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    rd_req_ready_i  = 1'b0;
    rd_beat_valid_i = 1'b0;
    rd_beat_data_i  = '0;
    forever begin
      @(negedge clk);
      if (hs_pending) begin
        beats_left = log_len[n_req-1] / 8;
        cur_word   = int'(log_addr[n_req-1] >> 3);
        hs_pending = 0;
      end
      if (beats_left > 0 && !(gap_on && gap_t)) begin
        rd_beat_valid_i = 1'b1;
        rd_beat_data_i  = mem[cur_word];
        cur_word++;
        beats_left--;
      end else begin
        rd_beat_valid_i = 1'b0;
      end
      gap_t = !gap_t;
      if (stall_cnt > 0) begin
        rd_req_ready_i = 1'b0;
        stall_cnt--;
      end else begin
        rd_req_ready_i = 1'b1;
      end
      if (rd_req_valid_o && !rd_req_ready_i) stall_seen++;
      if (rd_req_valid_o && rd_req_ready_i) begin
        log_addr[n_req] = rd_req_addr_o;
        log_len[n_req]  = int'(rd_req_bytes_o);
        n_req++;
        hs_pending = 1;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [31:0] p);
    @(negedge clk);
    push_valid_i = 1'b1;
    push_ptr_i   = p;
    @(negedge clk);
    push_valid_i = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic wait_done(input bit want_lt, input string tag);
    bit seen = 0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      seen = want_lt ? lt_done_o : desc_done_o;
    end
    check(seen, tag, 64'(seen), 64'd1);
  endtask

  task automatic read_desc(input int i, output logic [63:0] v);
    desc_rd_idx_i = 3'(i);
    #1;
    v = desc_rd_data_o;
  endtask

  task automatic read_lt(input int i, output logic [63:0] v);
    lt_rd_idx_i = 2'(i);
    #1;
    v = lt_rd_data_o;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) begin
      read_desc(i, v);
      check(v == 0, "R1 desc buffer zero", v, 0);
    end
    for (int i = 0; i < 4; i++) begin
      read_lt(i, v);
      check(v == 0, "R1 link buffer zero", v, 0);
    end
    check(fifo_level_o == 0 && !overflow_o && !rd_req_valid_o && !walk_active_o,
          "R1 idle outputs", {fifo_level_o, overflow_o, rd_req_valid_o, walk_active_o}, 0);
  endtask

  task automatic t_misaligned();
    push(32'h0000_0004);
    cycles(6);
    check(fifo_level_o == 0, "R4 misaligned not queued", 64'(fifo_level_o), 0);
    check(n_req == 0, "R4 misaligned not fetched", 64'(n_req), 0);
  endtask

  task automatic t_desc_fetch();
    logic [63:0] v;
    stall_cnt = 6;
    gap_on = 1;
    push(32'h0000_0000);
    wait_done(0, "R2 descriptor done");
    check(stall_seen > 0, "R10 request waited under stall", 64'(stall_seen), 1);
    check(n_req == 1 && log_addr[0] == 32'h0, "R10 single request at address", 64'(log_addr[0]), 0);
    check(log_len[0] == 64, "R2 descriptor byte count", 64'(log_len[0]), 64);
    for (int i = 0; i < 8; i++) begin
      read_desc(i, v);
      check(v == mem[i], "R2 descriptor dword", v, mem[i]);
    end
    check(walk_active_o && entry_idx_o == 0, "R7 walk starts at entry 0", 64'(entry_idx_o), 0);
  endtask

  task automatic t_walk_chain();
    logic [63:0] v;
    int nb;
    step();
    cycles(3);
    check(entry_idx_o == 1 && n_req == 1, "R7 no-jump step advances only", 64'(n_req), 1);
    nb = n_req;
    step();
    wait_done(1, "R6 link table done");
    check(log_addr[nb] == 32'h100 && log_len[nb] == 32, "R6 link request", 64'(log_addr[nb]), 64'h100);
    for (int i = 0; i < 4; i++) begin
      read_lt(i, v);
      check(v == mem[32+i], "R6 link dword", v, mem[32+i]);
    end
    wait_done(1, "R8 chained link done");
    check(log_addr[nb+1] == 32'h140 && log_len[nb+1] == 32, "R8 lowest flagged entry chains",
          64'(log_addr[nb+1]), 64'h140);
    read_lt(1, v);
    check(v == mem[41], "R8 chained link contents", v, mem[41]);
    cycles(3);
    check(n_req == nb + 2, "R8 chain stops without next flag", 64'(n_req), 64'(nb+2));
    for (int e = 2; e < 7; e++) step();
    cycles(2);
    check(!walk_active_o && entry_idx_o == 7, "R7 walk ends after entry 6", 64'(entry_idx_o), 7);
    step();
    cycles(3);
    check(entry_idx_o == 7 && n_req == nb + 2, "R7 step outside walk ignored", 64'(entry_idx_o), 7);
  endtask

  task automatic t_priority();
    logic [63:0] v;
    int nb;
    logic [63:0] old0;
    nb = n_req;
    old0 = mem[0];
    push(32'h0000_0200);
    push(32'h0000_0040);
    while (!(beats_left > 0 && beats_left < 7)) @(negedge clk);
    read_desc(0, v);
    check(v == old0, "R5 old contents during fill", v, old0);
    wait_done(0, "R2 second descriptor done");
    read_desc(7, v);
    check(v == mem[71], "R2 second descriptor last dword", v, mem[71]);
    cycles(4);
    check(fifo_level_o == 1, "R9 pointer held during walk", 64'(fifo_level_o), 1);
    for (int e = 0; e < 7; e++) step();
    wait_done(1, "R6 final-entry link done");
    wait_done(0, "R9 next descriptor done");
    check(log_addr[nb+1] == 32'h180 && log_len[nb+1] == 32, "R9 link read first",
          64'(log_addr[nb+1]), 64'h180);
    check(log_addr[nb+2] == 32'h040 && log_len[nb+2] == 64, "R9 descriptor read second",
          64'(log_addr[nb+2]), 64'h40);
    read_desc(3, v);
    check(v == mem[11], "R2 third descriptor dword", v, mem[11]);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 4; i++) push(32'h0000_0300 + 32'(i*64));
    check(fifo_level_o == 4 && !overflow_o, "R3 four pointers held", 64'(fifo_level_o), 4);
    push(32'h0000_0400);
    check(fifo_level_o == 4, "R3 full push dropped", 64'(fifo_level_o), 4);
    check(overflow_o, "R3 overflow flag set", 64'(overflow_o), 1);
    cycles(3);
    check(overflow_o, "R3 overflow flag sticky", 64'(overflow_o), 1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 64'hDEAD_0000_0000_0000 | 64'(i);
    mem[0] = 64'hA5A5_0000_0000_0001;
    for (int k = 0; k < 7; k++)
      mem[k+1] = mk(16'(100+k), k == 1, (k == 1) ? 32'h100 : 32'h1000 + 32'(k*8));
    for (int k = 0; k < 4; k++)
      mem[32+k] = mk(16'(200+k), k >= 2, (k == 2) ? 32'h140 : (k == 3) ? 32'h1C0 : 32'h2000);
    for (int k = 0; k < 4; k++) mem[40+k] = mk(16'(300+k), 1'b0, 32'h3000 + 32'(k*8));
    for (int k = 0; k < 4; k++) mem[48+k] = mk(16'(400+k), 1'b0, 32'h4000 + 32'(k*8));
    mem[64] = 64'hB4B4_0000_0000_0002;
    for (int k = 0; k < 7; k++)
      mem[65+k] = mk(16'(500+k), k == 6, (k == 6) ? 32'h180 : 32'h5000);
    mem[8] = 64'hC3C3_0000_0000_0003;
    for (int k = 0; k < 7; k++) mem[9+k] = mk(16'(600+k), 1'b0, 32'h6000);

    rst_n = 1'b0;
    push_valid_i = 1'b0;
    push_ptr_i = '0;
    step_i = 1'b0;
    desc_rd_idx_i = '0;
    lt_rd_idx_i = '0;
    cycles(4);
    rst_n = 1'b1;
    cycles(2);

    t_reset();
    t_misaligned();
    t_desc_fetch();
    t_walk_chain();
    t_priority();
    t_overflow();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule